// File: doc/BRIEF.md
# Hop Field Validation Pipeline

This block decides, for each packet reaching a border router, whether the router's own current hop field in the packet's path header is acceptable. Three checks run in a fixed order. First, the interface the packet arrived on must match the hop field's ingress interface. Second, the current time must lie before the hop field's expiry. Third, the hop field's truncated MAC must match a freshly computed CMAC tag. The block only sees the current hop field. Every other hop field in the path passes by without being examined.

The MAC input is chained. The current hop field's timestamp, expiry field and both interface numbers fill the upper half of a single 128-bit message block. When a neighbouring hop field exists, the lower half carries a 64-bit link word taken from that hop field. Because each hop's tag covers its neighbour, checking one hop protects the whole path. The block folds in the precomputed CMAC subkey and hands exactly one block per packet to an external pipelined block cipher of fixed latency. The cipher core and the key schedule sit outside the block. A new packet may enter on every clock cycle. Decisions leave in the order the packets arrived, each carrying the packet's tag, a pass flag and a two-bit reason code.

Top module: `hfv_pipe`

## Requirements
- R1: When `in_arrival_if` differs from `in_hf_ing`, the decision carries reason code 1 (bad interface) and `out_pass` is low.
- R2: Let expiry = `in_hf_ts` + (`in_hf_exp` + 1) × `EXP_UNIT`, computed without wrap-around. When `now_time` ≥ expiry, the decision carries reason code 2 (expired). With `now_time` = expiry − 1 this check passes.
- R3: When bits [127:104] of `cipher_rsp_block` for the packet differ from `in_hf_mac`, the decision carries reason code 3 (MAC mismatch). When the first two checks pass and these bits match, the reason is 0 and `out_pass` is high.
- R4: When several checks fail, the reported reason is the first failing one in the order interface (1), expiry (2), MAC (3).
- R5: When `in_has_prev` is 1, the cipher block is {ts[31:0], exp[7:0], ing[11:0], egr[11:0], prev_link[63:0]} (ts in the most significant bits) XOR `subkey_k1`.
- R6: When `in_has_prev` is 0, the lower 64 bits of the message are padding 0x80 followed by 56 zero bits, and the block is XORed with `subkey_k2` instead.
- R7: Every packet sampled with `in_valid` high produces exactly one `cipher_req_valid` pulse, on the cycle after sampling. No request appears otherwise.
- R8: The decision for a packet sampled at one rising edge appears after rising edge `CIPH_LAT`+1 following it, with `out_tag` equal to its `in_tag`. Decisions keep arrival order, including back-to-back packets on consecutive cycles.
- R9: During and after reset, with no packet in flight, `out_valid` and `cipher_req_valid` are low. Whenever `out_valid` is low, `out_pass` is low and `out_reason` reads 0. `out_pass` is high only together with `out_valid` and reason 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A packet's hop field is presented this cycle |
| in_tag | input | TAG_W | Packet identifier returned with the decision |
| in_arrival_if | input | 12 | Interface the packet arrived on |
| in_hf_ts | input | 32 | Hop field timestamp |
| in_hf_exp | input | 8 | Hop field expiry-time field |
| in_hf_ing | input | 12 | Hop field ingress interface |
| in_hf_egr | input | 12 | Hop field egress interface |
| in_hf_mac | input | 24 | Hop field truncated MAC |
| in_has_prev | input | 1 | A neighbouring hop field exists for chaining |
| in_prev_link | input | 64 | Chaining word from the neighbouring hop field |
| now_time | input | 32 | Current time, same unit as the timestamp |
| subkey_k1 | input | 128 | Precomputed CMAC subkey for a full final block |
| subkey_k2 | input | 128 | Precomputed CMAC subkey for a padded final block |
| cipher_req_valid | output | 1 | Block presented to the cipher this cycle |
| cipher_req_block | output | 128 | Block to encrypt |
| cipher_rsp_block | input | 128 | Cipher output, CIPH_LAT cycles after its request |
| out_valid | output | 1 | Decision valid |
| out_tag | output | TAG_W | Tag of the decided packet |
| out_pass | output | 1 | Packet is to be forwarded |
| out_reason | output | 2 | 0 pass, 1 bad interface, 2 expired, 3 MAC mismatch |

## Verification
The assertions assume the cipher behind the port is a fixed-latency pipeline of exactly `CIPH_LAT` stages that never stalls. They also assume `in_valid` is a defined level at every edge once reset is released. The bench's stand-in cipher is a keyed mixing function with exactly that many register stages. The bench drives every input at the falling edge and holds `in_valid` low during reset. Random traffic places `now_time` close to the expiry on both sides and corrupts MACs and interface numbers on a fraction of packets. Directed bursts fill every cycle.

// File: rtl/hfv_pkg.sv
package hfv_pkg;
    localparam int BLK_W  = 128;
    localparam int TS_W   = 32;
    localparam int EXPF_W = 8;
    localparam int IF_W   = 12;
    localparam int MAC_W  = 24;
    localparam int LINK_W = BLK_W - TS_W - EXPF_W - 2 * IF_W;
    localparam int LIM_W  = TS_W + 16;

    typedef enum logic [1:0] {
        VERDICT_PASS    = 2'd0,
        VERDICT_BAD_IF  = 2'd1,
        VERDICT_EXPIRED = 2'd2,
        VERDICT_BAD_MAC = 2'd3
    } verdict_e;
endpackage

// File: rtl/hfv_screen.sv
module hfv_screen
    import hfv_pkg::*;
#(
    parameter int EXP_UNIT = 300
) (
    input  logic [IF_W-1:0]   arrival_if,
    input  logic [IF_W-1:0]   hf_ing,
    input  logic [TS_W-1:0]   hf_ts,
    input  logic [EXPF_W-1:0] hf_exp,
    input  logic [TS_W-1:0]   now_time,
    output verdict_e          early
);
    logic [LIM_W-1:0] limit;
    logic             expired;

    assign limit   = LIM_W'(hf_ts) + (LIM_W'(hf_exp) + LIM_W'(1)) * LIM_W'(EXP_UNIT);
    assign expired = LIM_W'(now_time) >= limit;

    always_comb begin
        if (arrival_if != hf_ing)
            early = VERDICT_BAD_IF;
        else if (expired)
            early = VERDICT_EXPIRED;
        else
            early = VERDICT_PASS;
    end
endmodule

// File: rtl/hfv_block.sv
module hfv_block
    import hfv_pkg::*;
(
    input  logic [TS_W-1:0]   hf_ts,
    input  logic [EXPF_W-1:0] hf_exp,
    input  logic [IF_W-1:0]   hf_ing,
    input  logic [IF_W-1:0]   hf_egr,
    input  logic              has_prev,
    input  logic [LINK_W-1:0] prev_link,
    input  logic [BLK_W-1:0]  k1,
    input  logic [BLK_W-1:0]  k2,
    output logic [BLK_W-1:0]  blk
);
    localparam logic [LINK_W-1:0] PAD = {8'h80, {(LINK_W-8){1'b0}}};

    logic [LINK_W-1:0] tail;
    logic [BLK_W-1:0]  mask;

    assign tail = has_prev ? prev_link : PAD;
    assign mask = has_prev ? k1 : k2;
    assign blk  = {hf_ts, hf_exp, hf_ing, hf_egr, tail} ^ mask;
endmodule

// File: rtl/hfv_delay.sv
module hfv_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= d;
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[DEPTH-1];
endmodule

// File: rtl/hfv_pipe.sv
module hfv_pipe
    import hfv_pkg::*;
#(
    parameter int CIPH_LAT = 4,
    parameter int TAG_W    = 8,
    parameter int EXP_UNIT = 300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [11:0]       in_arrival_if,
    input  logic [31:0]       in_hf_ts,
    input  logic [7:0]        in_hf_exp,
    input  logic [11:0]       in_hf_ing,
    input  logic [11:0]       in_hf_egr,
    input  logic [23:0]       in_hf_mac,
    input  logic              in_has_prev,
    input  logic [63:0]       in_prev_link,
    input  logic [31:0]       now_time,
    input  logic [127:0]      subkey_k1,
    input  logic [127:0]      subkey_k2,
    output logic              cipher_req_valid,
    output logic [127:0]      cipher_req_block,
    input  logic [127:0]      cipher_rsp_block,
    output logic              out_valid,
    output logic [TAG_W-1:0]  out_tag,
    output logic              out_pass,
    output logic [1:0]        out_reason
);
    localparam int CARRY_W = 1 + TAG_W + 2 + MAC_W;

    verdict_e         early_c;
    logic [BLK_W-1:0] blk_c;

    hfv_screen #(.EXP_UNIT(EXP_UNIT)) u_screen (
        .arrival_if (in_arrival_if),
        .hf_ing     (in_hf_ing),
        .hf_ts      (in_hf_ts),
        .hf_exp     (in_hf_exp),
        .now_time   (now_time),
        .early      (early_c)
    );

    hfv_block u_block (
        .hf_ts     (in_hf_ts),
        .hf_exp    (in_hf_exp),
        .hf_ing    (in_hf_ing),
        .hf_egr    (in_hf_egr),
        .has_prev  (in_has_prev),
        .prev_link (in_prev_link),
        .k1        (subkey_k1),
        .k2        (subkey_k2),
        .blk       (blk_c)
    );

    // Stage 1: checks that need no cipher, plus the cipher request
    logic             s1_vld;
    logic [TAG_W-1:0] s1_tag;
    verdict_e         s1_early;
    logic [MAC_W-1:0] s1_mac;
    logic [BLK_W-1:0] s1_blk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_vld   <= 1'b0;
            s1_tag   <= '0;
            s1_early <= VERDICT_PASS;
            s1_mac   <= '0;
            s1_blk   <= '0;
        end else begin
            s1_vld <= in_valid;
            if (in_valid) begin
                s1_tag   <= in_tag;
                s1_early <= early_c;
                s1_mac   <= in_hf_mac;
                s1_blk   <= blk_c;
            end
        end
    end

    assign cipher_req_valid = s1_vld;
    assign cipher_req_block = s1_blk;

    // Side-band carried alongside the cipher pipeline
    logic [CARRY_W-1:0] carry_in;
    logic [CARRY_W-1:0] carry_out;

    assign carry_in = {s1_vld, s1_tag, s1_early, s1_mac};

    hfv_delay #(.W(CARRY_W), .DEPTH(CIPH_LAT)) u_align (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (carry_in),
        .q     (carry_out)
    );

    logic             al_vld;
    logic [TAG_W-1:0] al_tag;
    verdict_e         al_early;
    logic [MAC_W-1:0] al_mac;
    logic             tag_ok;
    verdict_e         final_c;

    assign al_vld   = carry_out[CARRY_W-1];
    assign al_tag   = carry_out[CARRY_W-2 -: TAG_W];
    assign al_early = verdict_e'(carry_out[MAC_W +: 2]);
    assign al_mac   = carry_out[MAC_W-1:0];
    assign tag_ok   = cipher_rsp_block[BLK_W-1 -: MAC_W] == al_mac;

    always_comb begin
        unique case (al_early)
            VERDICT_PASS:    final_c = tag_ok ? VERDICT_PASS : VERDICT_BAD_MAC;
            VERDICT_BAD_IF:  final_c = VERDICT_BAD_IF;
            VERDICT_EXPIRED: final_c = VERDICT_EXPIRED;
            VERDICT_BAD_MAC: final_c = VERDICT_BAD_MAC;
        endcase
    end

    // Output stage
    verdict_e reason_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_tag   <= '0;
            out_pass  <= 1'b0;
            reason_q  <= VERDICT_PASS;
        end else begin
            out_valid <= al_vld;
            out_tag   <= al_vld ? al_tag : '0;
            out_pass  <= al_vld && (al_early == VERDICT_PASS) && tag_ok;
            reason_q  <= al_vld ? final_c : VERDICT_PASS;
        end
    end

    assign out_reason = reason_q;
endmodule

// File: rtl/hfv_pipe_chk.sv
module hfv_pipe_chk #(
    parameter int CIPH_LAT = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       cipher_req_valid,
    input logic       out_valid,
    input logic       out_pass,
    input logic [1:0] out_reason
);
    logic [15:0] inflight;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) inflight <= '0;
        else        inflight <= inflight + {15'd0, in_valid} - {15'd0, out_valid};
    end

    // R7
    req_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> cipher_req_valid);

    // R7
    no_spurious_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !cipher_req_valid);

    // R9
    pass_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_pass |-> (out_valid && out_reason == 2'd0));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_reason == 2'd0 && !out_pass));

    // R8
    inflight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= 16'(CIPH_LAT + 2));

    // R8
    out_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> inflight != 16'd0);
endmodule

bind hfv_pipe hfv_pipe_chk #(.CIPH_LAT(CIPH_LAT)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .in_valid         (in_valid),
    .cipher_req_valid (cipher_req_valid),
    .out_valid        (out_valid),
    .out_pass         (out_pass),
    .out_reason       (out_reason)
);

// File: tb/hfv_pipe_tb.sv
`timescale 1ns/1ps
module hfv_pipe_tb;
    localparam int LAT   = 4;
    localparam int TAG_W = 8;
    localparam int UNIT  = 300;
    localparam logic [127:0] K1  = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
    localparam logic [127:0] K2  = 128'h0246_8ace_1357_9bdf_0f1e_2d3c_4b5a_6978;
    localparam logic [127:0] CKY = 128'h5a5a_c3c3_9696_0ff0_1234_fedc_a5a5_3c3c;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [TAG_W-1:0]  in_tag = '0;
    logic [11:0]       in_arrival_if = '0;
    logic [31:0]       in_hf_ts = '0;
    logic [7:0]        in_hf_exp = '0;
    logic [11:0]       in_hf_ing = '0;
    logic [11:0]       in_hf_egr = '0;
    logic [23:0]       in_hf_mac = '0;
    logic              in_has_prev = 1'b0;
    logic [63:0]       in_prev_link = '0;
    logic [31:0]       now_time = '0;
    logic              cipher_req_valid;
    logic [127:0]      cipher_req_block;
    logic [127:0]      cipher_rsp_block;
    logic              out_valid;
    logic [TAG_W-1:0]  out_tag;
    logic              out_pass;
    logic [1:0]        out_reason;

    always #5 clk = ~clk;

    hfv_pipe #(.CIPH_LAT(LAT), .TAG_W(TAG_W), .EXP_UNIT(UNIT)) u_dut (
        .clk, .rst_n, .in_valid, .in_tag, .in_arrival_if, .in_hf_ts, .in_hf_exp,
        .in_hf_ing, .in_hf_egr, .in_hf_mac, .in_has_prev, .in_prev_link, .now_time,
        .subkey_k1(K1), .subkey_k2(K2), .cipher_req_valid, .cipher_req_block,
        .cipher_rsp_block, .out_valid, .out_tag, .out_pass, .out_reason
    );

    function automatic logic [127:0] mix(input logic [127:0] x);
        logic [127:0] y;
        y = x ^ CKY;
        y = {y[90:0], y[127:91]} + {y[63:0], y[127:64]};
        return y ^ {y[31:0], y[127:32]};
    endfunction

    // Stand-in cipher: fixed LAT-stage pipeline
    logic [127:0] cpipe [LAT];
    always_ff @(posedge clk) begin
        cpipe[0] <= mix(cipher_req_block);
        for (int i = 1; i < LAT; i++) cpipe[i] <= cpipe[i-1];
    end
    assign cipher_rsp_block = cpipe[LAT-1];

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    bit done = 0;
    int           q_tag[$];
    int           q_reason[$];
    int           q_when[$];
    string        q_lbl[$];
    logic [127:0] q_blk[$];
    int           q_bwhen[$];
    string        q_blbl[$];

    task automatic fail(string req, string what, longint act, longint exp);
        miscompares++;
        $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    endtask

    task automatic monitor();
        if (cipher_req_valid) begin
            vectors++;
            if (q_blk.size() == 0) fail("R7", "unexpected cipher request", 1, 0);
            else begin
                logic [127:0] b;
                int w;
                string l;
                b = q_blk.pop_front();
                w = q_bwhen.pop_front();
                l = q_blbl.pop_front();
                if (cipher_req_block !== b) begin
                    fail(l, "cipher block hi", longint'(cipher_req_block[127:64]), longint'(b[127:64]));
                    fail(l, "cipher block lo", longint'(cipher_req_block[63:0]), longint'(b[63:0]));
                end
                if (cyc - w != 0) fail("R7", "request cycle", cyc - w, 0);
            end
        end
        if (out_valid) begin
            vectors++;
            if (q_tag.size() == 0) fail("R8", "unexpected decision", 1, 0);
            else begin
                int t, r, w;
                string l;
                t = q_tag.pop_front();
                r = q_reason.pop_front();
                w = q_when.pop_front();
                l = q_lbl.pop_front();
                if (int'(out_tag) != t)           fail("R8", "tag order", out_tag, t);
                if (cyc - w != LAT + 1)           fail("R8", "latency", cyc - w, LAT + 1);
                if (int'(out_reason) != r)        fail(l, "reason", out_reason, r);
                if (out_pass != (r == 0))         fail(l, "pass", out_pass, (r == 0));
            end
        end else begin
            vectors++;
            if (out_pass || out_reason != 2'd0) fail("R9", "idle output", {out_pass, out_reason}, 0);
        end
    endtask

    task automatic step();
        @(negedge clk);
        monitor();
        cyc++;
        in_valid = 1'b0;
    endtask

    // mac_ok: 1 gives the correct MAC, 0 a corrupted one
    task automatic send(input logic [11:0] arr, input logic [11:0] ing, input logic [31:0] ts,
                        input logic [7:0] ex, input logic has_prev, input logic [63:0] link,
                        input longint now, input bit mac_ok, input string lbl);
        logic [127:0] blk;
        logic [23:0]  mac;
        longint       lim;
        int           r;
        logic [11:0]  egr;
        egr = 12'($urandom);
        blk = has_prev ? {ts, ex, ing, egr, link} ^ K1
                       : {ts, ex, ing, egr, 8'h80, 56'd0} ^ K2;
        mac = mix(blk)[127:104];
        if (!mac_ok) mac = mac ^ 24'h000401;
        lim = longint'(ts) + (longint'(ex) + 1) * UNIT;
        if (arr != ing)   r = 1;
        else if (now >= lim) r = 2;
        else if (!mac_ok) r = 3;
        else r = 0;
        in_valid      = 1'b1;
        in_tag        = in_tag + 1'b1;
        in_arrival_if = arr;
        in_hf_ing     = ing;
        in_hf_egr     = egr;
        in_hf_ts      = ts;
        in_hf_exp     = ex;
        in_has_prev   = has_prev;
        in_prev_link  = link;
        in_hf_mac     = mac;
        now_time      = 32'(now);
        q_tag.push_back(int'(in_tag));
        q_reason.push_back(r);
        q_when.push_back(cyc);
        q_lbl.push_back(lbl);
        q_blk.push_back(blk);
        q_bwhen.push_back(cyc);
        q_blbl.push_back(has_prev ? "R5" : "R6");
    endtask

    function automatic longint lim_of(input logic [31:0] ts, input logic [7:0] ex);
        return longint'(ts) + (longint'(ex) + 1) * UNIT;
    endfunction

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5eed_1e55);
        // R9: reset state
        repeat (3) begin
            @(negedge clk);
            vectors++;
            if (out_valid || cipher_req_valid || out_pass)
                fail("R9", "reset outputs", {out_valid, cipher_req_valid, out_pass}, 0);
        end
        rst_n = 1'b1;
        step();

        // R2 boundary: one before expiry passes, at expiry drops
        step(); send(12'd7, 12'd7, 32'd1000, 8'd3, 1'b1, 64'h1122_3344_5566_7788, lim_of(32'd1000, 8'd3) - 1, 1, "R2");
        step(); send(12'd7, 12'd7, 32'd1000, 8'd3, 1'b1, 64'h1122_3344_5566_7788, lim_of(32'd1000, 8'd3), 1, "R2");
        // R1: bad interface
        step(); send(12'd5, 12'd6, 32'd4000, 8'd9, 1'b0, 64'd0, 32'd4000, 1, "R1");
        // R4: all fail -> 1; expiry and MAC fail -> 2
        step(); send(12'd5, 12'd9, 32'd10, 8'd0, 1'b1, 64'hdead, 32'd99999, 0, "R4");
        step(); send(12'd9, 12'd9, 32'd10, 8'd0, 1'b1, 64'hdead, 32'd99999, 0, "R4");
        // R3: MAC only
        step(); send(12'd3, 12'd3, 32'd500, 8'd200, 1'b1, 64'hcafe_f00d, 32'd600, 0, "R3");
        // R6 / R5: chaining and padding with good MAC
        step(); send(12'd1, 12'd1, 32'd800, 8'd50, 1'b0, 64'hffff_ffff_ffff_ffff, 32'd800, 1, "R6");
        step(); send(12'd1, 12'd1, 32'd800, 8'd50, 1'b1, 64'hffff_ffff_ffff_ffff, 32'd800, 1, "R5");
        // R8: back-to-back burst
        for (int i = 0; i < 10; i++) begin
            step();
            send(12'(i), 12'(i), 32'(i * 77), 8'(i), i[0], {32'(i), 32'hA5A5_0000}, i * 77, i % 3 != 0, "R8");
        end

        // Random traffic
        for (int n = 0; n < 600; n++) begin
            logic [11:0] arr, ing;
            logic [31:0] ts;
            logic [7:0]  ex;
            longint      lim, now;
            bit          ok;
            string       l;
            step();
            if ($urandom % 4 == 0) continue;
            arr = 12'($urandom);
            ing = ($urandom % 6 == 0) ? arr ^ 12'h001 : arr;
            ts  = $urandom & 32'h3fff_ffff;
            ex  = 8'($urandom);
            lim = lim_of(ts, ex);
            case ($urandom % 4)
                0: now = lim - 1 - longint'($urandom % 300);
                1: now = lim + longint'($urandom % 50);
                2: now = lim - 1;
                default: now = lim;
            endcase
            ok = ($urandom % 4) != 0;
            if (arr != ing) l = "R1";
            else if (now >= lim) l = "R2";
            else l = "R3";
            send(arr, ing, ts, ex, 1'($urandom), {$urandom, $urandom}, now, ok, l);
        end

        repeat (LAT + 6) step();
        vectors++;
        if (q_tag.size() != 0 || q_blk.size() != 0)
            fail("R8", "pending decisions", q_tag.size(), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule